// File: doc/BRIEF.md
# Mode-Configurable Redundancy Voter

This block sits between four identical compute slots and the rest of the system. A 2-bit mode setting sets how the slot outputs are grouped. The slots can run as four independent lanes. They can form two self-checking pairs. Three of them can form one triple-redundant group. Or two of them can form a single self-checking pair. The block drives an enable to each slot, so slots that the current mode does not use are switched off. The block registers the resulting lane outputs. It also keeps a sticky error status word that a host can read and clear.

A pair only detects a disagreement between its two copies. It produces no output for that word and leaves recovery to the host. The triple group forwards the bitwise majority of its three copies. It marks the copy that disagrees with that majority. If all three copies differ from each other, it raises a separate uncorrectable bit. A copy that arrives without its partners (valid skew) is also logged as an error. A mode write is held as pending and takes effect only once the block is idle.

Top module: `redundancy_voter`

## Requirements
- R1: `mode_act` encodes the active grouping: 0 = four lanes, 1 = two pairs (slots 0/1 feed lane 0, slots 2/3 feed lane 1), 2 = triple group (slots 0,1,2 feed lane 0), 3 = single pair (slots 0/1 feed lane 0). `slot_en` is 4'b1111 in modes 0 and 1, 4'b0111 in mode 2 and 4'b0011 in mode 3.
- R2: In mode 0, lane i repeats slot i's data and valid one clock later, and no error bit is set.
- R3: In a pair mode, when both slots of a pair are valid and their words are equal, the pair's lane is valid one clock later and carries that word.
- R4: When both slots of a pair are valid and their words differ, the pair's lane stays invalid, and the error bits of both slots are set (status bit i belongs to slot i).
- R5: In mode 2, when all three slots are valid and at least two words agree, lane 0 is valid with the bitwise majority, and the error bit of each copy that differs from the majority is set.
- R6: In mode 2, when the three valid words all differ from each other, lane 0 stays invalid and status bit 4 (uncorrectable) is set, with no slot bit set.
- R7: Valid skew inside a group gives no lane output. In a pair it sets both slots' bits. In the triple group it sets the bit of each slot whose valid differs from the majority of the three valids.
- R8: The data and valid of slots that the active mode does not use are ignored. Lanes outside the mode stay invalid, and those slots never set error bits.
- R9: Status bits are sticky. A write with `sts_clr_wr` clears the bits that are one in `sts_clr_mask`. A new error in the same cycle wins over the clear.
- R10: A mode write becomes active only on a clock where no lane output is valid and no enabled slot asserts valid. Until then the old mode stays in force.
- R11: After reset the mode is 0, all lanes are invalid, and status and event flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Requested grouping |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Write-one-to-clear mask for status bits |
| slot_data | input | 4*W | Slot words, slot i in bits [i*W +: W] |
| slot_valid | input | 4 | Per-slot word valid |
| slot_en | output | 4 | Per-slot enable from the active mode |
| mode_act | output | 2 | Active grouping |
| lane_data | output | 4*W | Lane words, lane i in bits [i*W +: W] |
| lane_valid | output | 4 | Per-lane valid |
| err_status | output | 5 | Sticky status: bits 3:0 per slot, bit 4 uncorrectable |
| err_event | output | 5 | One-cycle flags of errors found on the previous clock |

## Verification
The assertions assume that slot valids are sampled only through `slot_en`. They also assume that the host uses the clear mask only as a write-one-to-clear pulse. Under these assumptions, status bits may fall only on a clear, and a mode switch may happen only on an idle clock. The stimulus changes mode only with all slot valids low. It applies each group vector for one clock and then clears the status on a clock with no valid word. In this way every vector starts from a clean status word. The one deliberate exception is the case of continuous valid traffic against a pending mode write.

// File: rtl/redundancy_voter.sv
module redundancy_voter #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [1:0]     mode_wdata,
  input  logic           sts_clr_wr,
  input  logic [4:0]     sts_clr_mask,
  input  logic [4*W-1:0] slot_data,
  input  logic [3:0]     slot_valid,
  output logic [3:0]     slot_en,
  output logic [1:0]     mode_act,
  output logic [4*W-1:0] lane_data,
  output logic [3:0]     lane_valid,
  output logic [4:0]     err_status,
  output logic [4:0]     err_event
);
  localparam logic [1:0] M_QUAD = 2'd0;
  localparam logic [1:0] M_DUAL = 2'd1;
  localparam logic [1:0] M_TRIP = 2'd2;
  localparam logic [1:0] M_SOLO = 2'd3;

  logic [W-1:0] d [4];
  for (genvar i = 0; i < 4; i++) begin : g_split
    assign d[i] = slot_data[i*W +: W];
  end

  logic [1:0] mode_pend;
  logic       pend;
  logic [3:0] v;
  logic       idle;

  assign slot_en = (mode_act == M_TRIP) ? 4'b0111 :
                   (mode_act == M_SOLO) ? 4'b0011 : 4'b1111;
  assign v    = slot_valid & slot_en;
  assign idle = (lane_valid == 4'd0) && (v == 4'd0);

  logic [W-1:0] maj;
  logic         vmaj;
  assign maj  = (d[0] & d[1]) | (d[0] & d[2]) | (d[1] & d[2]);
  assign vmaj = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);

  logic [3:0]     nv;
  logic [4*W-1:0] nd;
  logic [4:0]     ne;

  always_comb begin
    nv = '0;
    nd = '0;
    ne = '0;
    case (mode_act)
      M_QUAD: begin
        nv = v;
        nd = slot_data;
      end
      M_DUAL, M_SOLO: begin
        if (v[0] && v[1]) begin
          if (d[0] == d[1]) begin
            nv[0]      = 1'b1;
            nd[0 +: W] = d[0];
          end else begin
            ne[1:0] = 2'b11;
          end
        end else if (v[0] ^ v[1]) begin
          ne[1:0] = 2'b11;
        end
        if (mode_act == M_DUAL) begin
          if (v[2] && v[3]) begin
            if (d[2] == d[3]) begin
              nv[1]      = 1'b1;
              nd[W +: W] = d[2];
            end else begin
              ne[3:2] = 2'b11;
            end
          end else if (v[2] ^ v[3]) begin
            ne[3:2] = 2'b11;
          end
        end
      end
      M_TRIP: begin
        if (&v[2:0]) begin
          if (d[0] != d[1] && d[0] != d[2] && d[1] != d[2]) begin
            ne[4] = 1'b1;
          end else begin
            nv[0]      = 1'b1;
            nd[0 +: W] = maj;
            ne[0]      = d[0] != maj;
            ne[1]      = d[1] != maj;
            ne[2]      = d[2] != maj;
          end
        end else if (|v[2:0]) begin
          ne[0] = v[0] != vmaj;
          ne[1] = v[1] != vmaj;
          ne[2] = v[2] != vmaj;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_act   <= M_QUAD;
      mode_pend  <= M_QUAD;
      pend       <= 1'b0;
      lane_valid <= '0;
      lane_data  <= '0;
      err_event  <= '0;
      err_status <= '0;
    end else begin
      if (pend && idle) begin
        mode_act <= mode_pend;
        pend     <= 1'b0;
      end
      if (mode_wr) begin
        mode_pend <= mode_wdata;
        pend      <= 1'b1;
      end
      lane_valid <= nv;
      lane_data  <= nd;
      err_event  <= ne;
      err_status <= (err_status & ~(sts_clr_wr ? sts_clr_mask : 5'd0)) | ne;
    end
  end
endmodule

// File: rtl/redundancy_voter_chk.sv
module redundancy_voter_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sts_clr_wr,
  input logic [4:0]     sts_clr_mask,
  input logic [4*W-1:0] slot_data,
  input logic [3:0]     slot_en,
  input logic [1:0]     mode_act,
  input logic [4*W-1:0] lane_data,
  input logic [3:0]     lane_valid,
  input logic [4:0]     err_status,
  input logic [4:0]     err_event
);
  logic [W-1:0] s0, s1, s2, m;
  assign s0 = slot_data[0 +: W];
  assign s1 = slot_data[W +: W];
  assign s2 = slot_data[2*W +: W];
  assign m  = (s0 & s1) | (s0 & s2) | (s1 & s2);

  a_r1_trip_slot3_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'd2) |-> (slot_en[3] == 1'b0));
  a_r1_solo_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'd3) |-> (slot_en[3:2] == 2'b00));
  a_r8_lanes_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act != 2'd0) |-> (lane_valid[3:2] == 2'b00));
  a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act[1]) |-> (lane_valid[3:1] == 3'b000));
  a_r2_quad_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'd0) |=> (err_event == 5'd0));
  a_r5_trip_majority: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'd2 && lane_valid[0]) |-> (lane_data[W-1:0] == $past(m)));
  a_r6_uncorr_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
    err_event[4] |-> (lane_valid == 4'd0 && err_event[3:0] == 4'd0));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_clr_wr) |-> ((err_status & $past(err_status)) == $past(err_status)));
  a_r9_event_logged: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_status & err_event) == err_event));
  a_r10_switch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_act) |-> ($past(lane_valid) == 4'd0 && lane_valid == 4'd0));
endmodule

bind redundancy_voter redundancy_voter_chk #(.W(W)) u_chk (.*);

// File: tb/redundancy_voter_test.sv
module redundancy_voter_test;
  localparam int W = 4;
  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode_wr = 1'b0;
  logic [1:0]     mode_wdata = '0;
  logic           sts_clr_wr = 1'b0;
  logic [4:0]     sts_clr_mask = '0;
  logic [4*W-1:0] slot_data = '0;
  logic [3:0]     slot_valid = '0;
  logic [3:0]     slot_en;
  logic [1:0]     mode_act;
  logic [4*W-1:0] lane_data;
  logic [3:0]     lane_valid;
  logic [4:0]     err_status;
  logic [4:0]     err_event;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  redundancy_voter #(.W(W)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    slot_valid   = '0;
    sts_clr_wr   = 1'b1;
    sts_clr_mask = 5'h1f;
    @(negedge clk);
    sts_clr_wr   = 1'b0;
    sts_clr_mask = '0;
  endtask

  task automatic vec(input logic [3:0] v, input logic [W-1:0] a, b, c, e,
                     input logic [3:0] ev, input logic [4*W-1:0] ed,
                     input logic [4:0] ee, input string req);
    logic [4*W-1:0] msk;
    slot_valid = v;
    slot_data  = {e, c, b, a};
    @(negedge clk);
    msk = '0;
    for (int i = 0; i < 4; i++) if (ev[i]) msk[i*W +: W] = '1;
    chk(lane_valid == ev, {req, " lane_valid"}, lane_valid, ev);
    chk((lane_data & msk) == (ed & msk), {req, " lane_data"}, lane_data & msk, ed & msk);
    chk(err_status == ee, {req, " err_status"}, err_status, ee);
    clear_all();
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [3:0] en);
    slot_valid = '0;
    mode_wr    = 1'b1;
    mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode_act == m, "R1 mode_act", mode_act, m);
    chk(slot_en == en, "R1 slot_en", slot_en, en);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c, e, mj;
    logic [4:0] ee;
    logic [3:0] ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(mode_act == 2'd0, "R11 mode", mode_act, 0);
    chk(lane_valid == 4'd0, "R11 lane_valid", lane_valid, 0);
    chk(err_status == 5'd0 && err_event == 5'd0, "R11 status", err_status, 0);
    chk(slot_en == 4'hf, "R1 slot_en reset", slot_en, 4'hf);

    // R2 four independent lanes
    for (int i = 0; i < 64; i++) begin
      a = W'(i); b = W'(i * 3); c = W'(i * 5 + 1); e = W'(~i);
      vec(4'(i), a, b, c, e, 4'(i), {e, c, b, a}, 5'd0, "R2");
    end

    // R3 R4 two pairs
    set_mode(2'd1, 4'hf);
    for (int i = 0; i < 256; i++) begin
      a = W'(i >> 4); b = W'(i); c = b; e = W'((i >> 4) ^ (i & 1));
      ev = {2'b00, c == e, a == b};
      ee = {1'b0, c != e, c != e, a != b, a != b};
      vec(4'hf, a, b, c, e, ev, {W'(0), W'(0), c, a}, ee, (ee == 0) ? "R3" : "R4");
    end
    // R7 pair skew
    vec(4'b0100, 1, 1, 2, 2, 4'd0, '0, 5'b01100, "R7 pair skew");
    vec(4'b0010, 1, 1, 2, 2, 4'd0, '0, 5'b00011, "R7 pair skew");

    // R5 R6 R8 triple group, slot 3 fed junk
    set_mode(2'd2, 4'h7);
    for (int i = 0; i < 4096; i++) begin
      a = W'(i); b = W'(i >> 4); c = W'(i >> 8); e = W'(i * 7);
      mj = (a & b) | (a & c) | (b & c);
      if (a != b && a != c && b != c) begin
        ev = 4'd0; ee = 5'b10000;
      end else begin
        ev = 4'd1; ee = {1'b0, 1'b0, c != mj, b != mj, a != mj};
      end
      vec(4'hf, a, b, c, e, ev, {W'(0), W'(0), W'(0), mj}, ee,
          ee[4] ? "R6" : (ee == 0 ? "R5 R8" : "R5"));
    end
    // R7 triple skew
    vec(4'b0011, 3, 3, 3, 0, 4'd0, '0, 5'b00100, "R7 trip skew");
    vec(4'b0001, 3, 3, 3, 0, 4'd0, '0, 5'b00001, "R7 trip skew");
    vec(4'b1000, 3, 4, 5, 6, 4'd0, '0, 5'b00000, "R8 slot3 ignored");

    // single pair, slots 2 and 3 fed conflicting junk
    set_mode(2'd3, 4'h3);
    for (int i = 0; i < 256; i++) begin
      a = W'(i >> 4); b = W'(i); c = W'(i + 1); e = W'(i + 2);
      ev = {3'b000, a == b};
      ee = {3'b000, a != b, a != b};
      vec(4'hf, a, b, c, e, ev, {W'(0), W'(0), W'(0), a}, ee, "R3 R4 R8");
    end
    vec(4'b1100, 1, 2, 3, 4, 4'd0, '0, 5'd0, "R8 upper ignored");

    // R9 sticky, partial clear, set beats clear
    slot_valid = 4'b0011; slot_data = {W'(0), W'(0), W'(1), W'(2)};
    @(negedge clk);
    slot_valid = '0;
    repeat (4) @(negedge clk);
    chk(err_status == 5'b00011, "R9 sticky", err_status, 5'b00011);
    sts_clr_wr = 1'b1; sts_clr_mask = 5'b00001;
    @(negedge clk);
    sts_clr_wr = 1'b0;
    @(negedge clk);
    chk(err_status == 5'b00010, "R9 partial clear", err_status, 5'b00010);
    slot_valid = 4'b0011; sts_clr_wr = 1'b1; sts_clr_mask = 5'h1f;
    @(negedge clk);
    slot_valid = '0; sts_clr_wr = 1'b0;
    @(negedge clk);
    chk(err_status == 5'b00011, "R9 set wins", err_status, 5'b00011);
    clear_all();

    // R10 deferred mode change under traffic
    set_mode(2'd0, 4'hf);
    slot_valid = 4'hf; slot_data = {W'(4), W'(3), W'(2), W'(1)};
    mode_wr = 1'b1; mode_wdata = 2'd2;
    @(negedge clk);
    mode_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode_act == 2'd0, "R10 held", mode_act, 0);
    chk(lane_valid == 4'hf, "R10 old lanes", lane_valid, 4'hf);
    chk(err_status == 5'd0, "R10 no vote", err_status, 0);
    slot_valid = '0;
    repeat (3) @(negedge clk);
    chk(mode_act == 2'd2, "R10 applied", mode_act, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule